// File: doc/BRIEF.md
# Scanned Key Matrix Emulator

This block stands in for a physical keyboard matrix. A host feeds it a stream of one-byte scancodes. A firmware scan routine drives the column strobes and reads back the row sense lines, exactly as it would with real switches. Incoming scancodes are held in a small queue. A slow periodic tick applies them one at a time, so the scan routine sees key transitions at a human pace instead of in bursts.

Each scancode carries a press or release flag. Its low seven bits index a position table that the host loads through a write port. A position names a row and a column of the matrix, or one of a few discrete special-key lines that bypass the matrix altogether. The sense outputs are a pure function of the pressed-key state and the current strobes, so a strobe change is seen at once.

The event input is valid/ready. `ev_ready` is high whenever the queue has room. A transfer takes place on a clock edge where both `ev_valid` and `ev_ready` are high. A source that ignores back-pressure and asserts `ev_valid` while `ev_ready` is low loses that byte, and the sticky `ovf_flag` is raised.

Top module: `keymat_emu`

## Requirements
- R1: With 11 strobe inputs and 7 sense outputs, `sense_out[r]` is high exactly when some column `c` is both pressed in row `r` and high in `strobe_in`; it follows a strobe change in the same cycle, with no clock edge in between.
- R2: Scancode bit 7 set means release and clear means press; bits 6:0 select a table entry. When the event is applied, a press sets the bit of its row and column, and a release clears it.
- R3: A table entry with bit 7 set is unmapped, and the event is dropped with no output change. Otherwise bits 6:4 give the row and bits 3:0 the column. A matrix column of 11 or more has no effect.
- R4: An entry whose row field is 7 selects special line `special_out[col]` for a column of 0 to 4. A press drives that line high and a release drives it low, and the matrix is untouched. A column of 5 or more has no effect.
- R5: At most one queued event is applied per tick. A tick occurs every `TICK_DIV` clocks, first on the `TICK_DIV`-th rising edge after reset is released. The default divider gives 32 ticks per second at 125 MHz.
- R6: The queue holds 16 events in arrival order. `ev_ready` is high exactly when fewer than 16 events are queued.
- R7: An `ev_valid` while `ev_ready` is low discards the byte and sets `ovf_flag`, which stays high until reset.
- R8: Reset clears every row, every special line, the queue and `ovf_flag`, and returns every table entry to unmapped.
- R9: A table write (`map_wr`, `map_idx`, `map_pos`) takes effect for events applied on later edges. An event applied on the same edge uses the previous entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Scancode offered |
| ev_ready | output | 1 | Queue has room |
| ev_code | input | 8 | Scancode: bit 7 release, bits 6:0 table index |
| map_wr | input | 1 | Table write strobe |
| map_idx | input | 7 | Table entry to write |
| map_pos | input | 8 | Entry value: bit 7 unmapped, bits 6:4 row, bits 3:0 column |
| strobe_in | input | 11 | Column strobes from the scan routine |
| sense_out | output | 7 | Row sense lines |
| special_out | output | 5 | Discrete special-key lines |
| ovf_flag | output | 1 | Sticky: an event was lost to a full queue |

## Verification
Sense lines are combinational, so they are due in the same cycle as a strobe change. Key and special-line changes appear just after the tick edge that pops the event. That edge comes up to `TICK_DIV` edges after the push, plus one tick for each event already queued ahead of it. `ev_ready` and `ovf_flag` are due one edge after the push that changes the queue. A behavioural model in the bench advances on the same rising edges from the same inputs. Every output is compared against it at the following falling edge. Directed checks wait a whole number of tick periods, or measure the spacing of two transitions, before they sample.

// File: rtl/keymat_pkg.sv
package keymat_pkg;
  localparam int CODE_W  = 8;
  localparam int IDX_W   = 7;
  localparam int POS_W   = 8;
  localparam int ROW_LSB = 4;
  localparam int ROW_W   = 3;
  localparam int COL_W   = 4;
  typedef logic [POS_W-1:0] pos_t;
  localparam pos_t POS_NONE = 8'h80;

  function automatic logic pos_unmapped(pos_t p);
    return p[POS_W-1];
  endfunction
  function automatic logic [ROW_W-1:0] pos_row(pos_t p);
    return p[ROW_LSB +: ROW_W];
  endfunction
  function automatic logic [COL_W-1:0] pos_col(pos_t p);
    return p[COL_W-1:0];
  endfunction
endpackage

// File: rtl/keymat_ticker.sv
module keymat_ticker #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/keymat_fifo.sv
module keymat_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] cnt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/keymat_map.sv
module keymat_map
  import keymat_pkg::*;
#(
  parameter int ENTRIES = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [IDX_W-1:0] wr_idx,
  input  pos_t             wr_pos,
  input  logic [IDX_W-1:0] rd_idx,
  output pos_t             rd_pos
);
  pos_t tbl [ENTRIES];

  assign rd_pos = tbl[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= POS_NONE;
    end else if (wr) begin
      tbl[wr_idx] <= wr_pos;
    end
  end
endmodule

// File: rtl/keymat_matrix.sv
module keymat_matrix
  import keymat_pkg::*;
#(
  parameter int N_STROBE  = 11,
  parameter int N_SENSE   = 7,
  parameter int N_SPECIAL = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 apply,
  input  logic                 release_n_press,
  input  pos_t                 pos,
  input  logic [N_STROBE-1:0]  strobe,
  output logic [N_SENSE-1:0]   sense,
  output logic [N_SPECIAL-1:0] special
);
  localparam int SPECIAL_ROW = N_SENSE;

  logic [N_STROBE-1:0] rows [N_SENSE];
  logic                hit;

  assign hit = apply && !pos_unmapped(pos);

  for (genvar r = 0; r < N_SENSE; r++) begin : g_row
    for (genvar c = 0; c < N_STROBE; c++) begin : g_col
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          rows[r][c] <= 1'b0;
        else if (hit && pos_row(pos) == ROW_W'(r) && pos_col(pos) == COL_W'(c))
          rows[r][c] <= !release_n_press;
      end
    end
    assign sense[r] = |(rows[r] & strobe);
  end

  for (genvar k = 0; k < N_SPECIAL; k++) begin : g_spec
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        special[k] <= 1'b0;
      else if (hit && pos_row(pos) == ROW_W'(SPECIAL_ROW) && pos_col(pos) == COL_W'(k))
        special[k] <= !release_n_press;
    end
  end
endmodule

// File: rtl/keymat_emu.sv
module keymat_emu
  import keymat_pkg::*;
#(
  parameter int          N_STROBE   = 11,
  parameter int          N_SENSE    = 7,
  parameter int          N_SPECIAL  = 5,
  parameter int          FIFO_DEPTH = 16,
  parameter int unsigned TICK_DIV   = 3906250
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_valid,
  output logic                 ev_ready,
  input  logic [7:0]           ev_code,
  input  logic                 map_wr,
  input  logic [6:0]           map_idx,
  input  logic [7:0]           map_pos,
  input  logic [N_STROBE-1:0]  strobe_in,
  output logic [N_SENSE-1:0]   sense_out,
  output logic [N_SPECIAL-1:0] special_out,
  output logic                 ovf_flag
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int CW      = $clog2(FIFO_DEPTH + 1);

  logic              tick;
  logic              q_full, q_empty, pop;
  logic [CW-1:0]     q_cnt;
  logic [CODE_W-1:0] head;
  pos_t              head_pos;

  keymat_ticker #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  assign pop = tick && !q_empty;

  keymat_fifo #(.DEPTH(FIFO_DEPTH), .W(CODE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(ev_valid), .din(ev_code),
    .pop(pop), .head(head),
    .full(q_full), .empty(q_empty), .cnt(q_cnt)
  );

  assign ev_ready = !q_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ovf_flag <= 1'b0;
    else if (ev_valid && q_full) ovf_flag <= 1'b1;
  end

  keymat_map #(.ENTRIES(ENTRIES)) u_map (
    .clk(clk), .rst_n(rst_n),
    .wr(map_wr), .wr_idx(map_idx), .wr_pos(map_pos),
    .rd_idx(head[IDX_W-1:0]), .rd_pos(head_pos)
  );

  keymat_matrix #(.N_STROBE(N_STROBE), .N_SENSE(N_SENSE), .N_SPECIAL(N_SPECIAL)) u_mat (
    .clk(clk), .rst_n(rst_n),
    .apply(pop), .release_n_press(head[CODE_W-1]), .pos(head_pos),
    .strobe(strobe_in), .sense(sense_out), .special(special_out)
  );
endmodule

// File: rtl/keymat_emu_chk.sv
module keymat_emu_chk #(
  parameter int N_STROBE   = 11,
  parameter int N_SENSE    = 7,
  parameter int N_SPECIAL  = 5,
  parameter int FIFO_DEPTH = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           ev_valid,
  input logic                           ev_ready,
  input logic [N_STROBE-1:0]            strobe_in,
  input logic [N_SENSE-1:0]             sense_out,
  input logic [N_SPECIAL-1:0]           special_out,
  input logic                           ovf_flag,
  input logic                           tick,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] q_cnt
);
  a_r1_no_strobe_no_sense: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_in == '0) |-> (sense_out == '0));

  a_r2_keys_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (!$stable(strobe_in) || $stable(sense_out)));

  a_r4_special_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(special_out));

  a_r5_one_pop_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt < $past(q_cnt)) |-> (q_cnt == $past(q_cnt) - 1'b1));

  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH));

  a_r7_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> ovf_flag);

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);
endmodule

bind keymat_emu keymat_emu_chk #(
  .N_STROBE(N_STROBE), .N_SENSE(N_SENSE), .N_SPECIAL(N_SPECIAL), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .strobe_in(strobe_in), .sense_out(sense_out), .special_out(special_out),
  .ovf_flag(ovf_flag), .tick(tick), .q_cnt(q_cnt)
);

// File: tb/keymat_emu_tb.sv
module keymat_emu_tb;
  localparam int TDIV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [7:0]  ev_code = '0;
  logic        map_wr = 1'b0;
  logic [6:0]  map_idx = '0;
  logic [7:0]  map_pos = '0;
  logic [10:0] strobe_in = '0;
  logic [6:0]  sense_out;
  logic [4:0]  special_out;
  logic        ovf_flag;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  keymat_emu #(.TICK_DIV(TDIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_code(ev_code), .map_wr(map_wr), .map_idx(map_idx), .map_pos(map_pos),
    .strobe_in(strobe_in), .sense_out(sense_out), .special_out(special_out),
    .ovf_flag(ovf_flag)
  );

  // ---------------- behavioural reference ----------------
  logic [10:0] m_rows [7];
  logic [4:0]  m_spec;
  logic [7:0]  m_map [128];
  int          m_q [$];
  int          m_tc;
  bit          m_ovf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < 7; r++) m_rows[r] = '0;
      for (int i = 0; i < 128; i++) m_map[i] = 8'h80;
      m_spec = '0; m_q.delete(); m_tc = 0; m_ovf = 0;
    end else begin
      bit tk, acc;
      tk  = (m_tc == TDIV - 1);
      m_tc = tk ? 0 : m_tc + 1;
      acc = ev_valid && (m_q.size() < 16);
      if (ev_valid && m_q.size() >= 16) m_ovf = 1;
      if (tk && m_q.size() > 0) begin
        int code, p, row, col;
        code = m_q.pop_front();
        p = m_map[code & 127];
        if (p < 128) begin
          row = p / 16; col = p % 16;
          if (row < 7 && col < 11) m_rows[row][col] = (code < 128);
          else if (row == 7 && col < 5) m_spec[col] = (code < 128);
        end
      end
      if (acc) m_q.push_back(int'(ev_code));
      if (map_wr) m_map[map_idx] = map_pos;
    end
  end

  function automatic logic [6:0] m_sense();
    logic [6:0] s;
    for (int r = 0; r < 7; r++) s[r] = |(m_rows[r] & strobe_in);
    return s;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(sense_out == m_sense(), "R1 sense vs model", sense_out, m_sense());
    chk(special_out == m_spec, "R4 special vs model", special_out, m_spec);
    chk(ev_ready == (m_q.size() < 16), "R6 ready vs model", ev_ready, m_q.size() < 16);
    chk(ovf_flag == m_ovf, "R7 overflow vs model", ovf_flag, m_ovf);
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic wait_n(int n);
    repeat (n) step();
  endtask

  task automatic push(logic [7:0] c);
    ev_valid = 1'b1; ev_code = c;
    step();
    ev_valid = 1'b0;
  endtask

  task automatic wmap(logic [6:0] i, logic [7:0] p);
    map_wr = 1'b1; map_idx = i; map_pos = p;
    step();
    map_wr = 1'b0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog R5 progress actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t_a, t_b, cyc;
    wait_n(3);
    rst_n = 1'b1;
    step();
    // R8: reset state
    chk(sense_out == 0 && special_out == 0, "R8 outputs after reset", {special_out, sense_out}, 0);
    chk(ev_ready == 1 && ovf_flag == 0, "R8 ready/ovf after reset", {ev_ready, ovf_flag}, 2);

    wmap(7'h10, 8'h23);  // row2 col3
    wmap(7'h11, 8'h00);  // row0 col0
    wmap(7'h12, 8'h72);  // special 2
    wmap(7'h13, 8'h0B);  // col 11: no effect
    wmap(7'h15, 8'h65);  // row6 col5
    wmap(7'h16, 8'h75);  // special 5: no effect
    strobe_in = '1;
    wait_n(2 * TDIV);

    // R5: two events queued back to back are applied one tick apart
    push(8'h10); push(8'h11);
    t_a = -1; t_b = -1; cyc = 0;
    repeat (4 * TDIV) begin
      step(); cyc++;
      if (t_a < 0 && sense_out[2]) t_a = cyc;
      if (t_b < 0 && sense_out[0]) t_b = cyc;
    end
    chk(t_a > 0 && t_b - t_a == TDIV, "R5 tick spacing", t_b - t_a, TDIV);
    chk(sense_out == 7'b0000101, "R2 two presses", sense_out, 7'b0000101);

    push(8'h90);
    wait_n(2 * TDIV);
    chk(sense_out == 7'b0000001, "R2 release", sense_out, 7'b0000001);

    push(8'h15);
    wait_n(2 * TDIV);
    strobe_in = 11'h001; step();
    chk(sense_out == 7'b0000001, "R1 column 0 strobe", sense_out, 7'b0000001);
    strobe_in = 11'h020; step();
    chk(sense_out == 7'b1000000, "R1 column 5 strobe", sense_out, 7'b1000000);
    strobe_in = 11'h000; step();
    chk(sense_out == 7'b0000000, "R1 no strobe", sense_out, 0);
    strobe_in = '1;

    push(8'h12);
    wait_n(2 * TDIV);
    chk(special_out == 5'b00100, "R4 special press", special_out, 5'b00100);
    chk(sense_out == 7'b1000001, "R4 matrix untouched", sense_out, 7'b1000001);
    push(8'h92);
    wait_n(2 * TDIV);
    chk(special_out == 5'b00000, "R4 special release", special_out, 0);

    push(8'h14); push(8'h13); push(8'h16);
    wait_n(4 * TDIV);
    chk(sense_out == 7'b1000001, "R3 unmapped/out-of-range ignored", sense_out, 7'b1000001);
    chk(special_out == 0, "R4 special index 5 ignored", special_out, 0);

    wmap(7'h14, 8'h14);  // row1 col4
    push(8'h14);
    wait_n(2 * TDIV);
    chk(sense_out == 7'b1000011, "R9 rewritten entry", sense_out, 7'b1000011);

    // R6/R7: ignore back-pressure for 24 cycles
    ev_valid = 1'b1;
    for (int i = 0; i < 24; i++) begin
      ev_code = (i % 2 == 0) ? 8'h94 : 8'h14;
      step();
      if (i == 20) begin
        chk(ev_ready == 0, "R6 ready low when full", ev_ready, 0);
        chk(ovf_flag == 1, "R7 overflow set", ovf_flag, 1);
      end
    end
    ev_valid = 1'b0;
    wait_n(20 * TDIV);
    chk(ev_ready == 1, "R6 ready after drain", ev_ready, 1);
    chk(ovf_flag == 1, "R7 overflow sticky", ovf_flag, 1);

    // R8: reset mid-run
    rst_n = 1'b0;
    wait_n(2);
    rst_n = 1'b1;
    step();
    chk(sense_out == 0 && special_out == 0, "R8 rows cleared", {special_out, sense_out}, 0);
    chk(ovf_flag == 0 && ev_ready == 1, "R8 ovf/queue cleared", {ev_ready, ovf_flag}, 2);
    push(8'h10);
    wait_n(2 * TDIV);
    chk(sense_out == 0, "R8 table back to unmapped", sense_out, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule